// File: doc/BRIEF.md
# Extended-Register Add/Subtract Execute Unit

This block decodes one 32-bit add/subtract instruction word of the extended-register form and executes it. It presents the two source register numbers on read-address outputs. It takes the read data back from an external register file, together with the current stack pointer. Operand 1 is a general register or the stack pointer. Operand 2 is a general register, or zero, and it passes through an extend stage and a small left shift. The unit then adds or subtracts at 32-bit or 64-bit width and can produce condition flags.

The results are captured in one register stage. The outputs are a write-back request to a general register or to the stack pointer, the flag value and its write enable, and two fault indications: the word is not this instruction, or the word is an illegal encoding of it. A word is accepted when valid_i is high, and its outcome appears with valid_o one clock later. The register file, flag storage and fetch sit outside the block.

Top module: `addsub_ext_exec`

## Requirements
- R1: The read addresses are combinational from the instruction: rn_idx_o = instr_i[9:5] and rm_idx_o = instr_i[20:16].
- R2: The extend code instr_i[15:13] selects the part of operand 2 that is used. Bits [1:0] pick the size: 0 is byte, 1 is halfword, 2 is word, 3 is doubleword. Bit [2] set means sign extension and clear means zero extension.
- R3: The extended value is shifted left by instr_i[12:10]. A shift code above 4 sets undef_o and raises no write enable.
- R4: A word with the fixed pattern but with instr_i[23:22] not equal to 00 sets undef_o and raises no write enable.
- R5: A word with instr_i[28:24] not equal to 01011, or with instr_i[21] equal to 0, sets nomatch_o. It clears undef_o and raises no write enable.
- R6: When Rn is 31, operand 1 is taken from sp_data_i. When Rm is 31, operand 2 reads as zero. In both cases the port data is ignored.
- R7: When instr_i[30] is 1, the unit subtracts operand 2 from operand 1. C is then 1 when no borrow occurs. When instr_i[30] is 0, the unit adds.
- R8: When instr_i[29] is 1, flags_we_o is set and nzcv_o = {N,Z,C,V}. N is the result MSB, Z means the result is zero, C is the carry out and V is signed overflow. When instr_i[29] is 0, flags_we_o stays low.
- R9: Rd = 31 with instr_i[29] = 0 writes the 64-bit zero-extended result to the stack pointer through sp_we_o. Rd = 31 with instr_i[29] = 1 writes no register. Any other Rd raises gpr_we_o with gpr_waddr_o = Rd.
- R10: When instr_i[31] is 0, the operation is 32 bits wide. The flags come from 32-bit values, and wdata_o holds the result zero-extended to 64 bits.
- R11: A word accepted with valid_i produces its outputs with valid_o one clock later. A cycle without valid_i leaves valid_o and every write enable low on the next clock.
- R12: While rst_ni is low, every output flag and enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction word present |
| instr_i | input | 32 | Instruction word |
| rn_idx_o | output | 5 | Read address of the first source |
| rm_idx_o | output | 5 | Read address of the second source |
| rn_data_i | input | 64 | Register data at rn_idx_o |
| rm_data_i | input | 64 | Register data at rm_idx_o |
| sp_data_i | input | 64 | Current stack pointer |
| valid_o | output | 1 | Result present |
| nomatch_o | output | 1 | Word is not this instruction |
| undef_o | output | 1 | Illegal encoding |
| gpr_we_o | output | 1 | General register write enable |
| gpr_waddr_o | output | 5 | General register write address |
| sp_we_o | output | 1 | Stack pointer write enable |
| flags_we_o | output | 1 | Flag write enable |
| wdata_o | output | 64 | Write-back data |
| nzcv_o | output | 4 | Flag value {N,Z,C,V} |

## Verification
A table of hand-computed vectors separates the individual features. These include zero versus sign extension of a byte whose top bit is set, a subtraction that yields zero, and a 32-bit add that wraps with both carry and overflow. They also cover a shift of 4 into a stack-pointer write, Rm = 31 when the register file holds a nonzero value at index 31, Rd = 31 with the flags set, and a shift code of 5. Random words are then checked against a reference model. That model works out carry and overflow by wide arithmetic rather than by gate equations. About one word in eight has a broken fixed pattern, and about one in four has a nonzero reserved field. The random register contents exercise every extend code at both widths and for both operations. Directed cases cover reset, an idle cycle and the read-address outputs.

// File: rtl/addsub_ext_pkg.sv
package addsub_ext_pkg;
  localparam int unsigned INSN_W    = 32;
  localparam int unsigned RIDX_W    = 5;
  localparam int unsigned MAX_SHIFT = 4;
  localparam logic [4:0]  FIXED_HI  = 5'b01011;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DBL  = 2'd3
  } ext_size_e;

  typedef struct packed {
    logic            wide;
    logic            sub;
    logic            setf;
    logic            sign;
    ext_size_e       size;
    logic [2:0]      shamt;
    logic [RIDX_W-1:0] rn;
    logic [RIDX_W-1:0] rm;
    logic [RIDX_W-1:0] rd;
  } insn_fields_t;
endpackage

// File: rtl/addsub_ext_decode.sv
module addsub_ext_decode
  import addsub_ext_pkg::*;
(
  input  logic [INSN_W-1:0] instr_i,
  output insn_fields_t      fld_o,
  output logic              match_o,
  output logic              undef_o
);
  always_comb begin
    fld_o.wide  = instr_i[31];
    fld_o.sub   = instr_i[30];
    fld_o.setf  = instr_i[29];
    fld_o.sign  = instr_i[15];
    fld_o.size  = ext_size_e'(instr_i[14:13]);
    fld_o.shamt = instr_i[12:10];
    fld_o.rm    = instr_i[20:16];
    fld_o.rn    = instr_i[9:5];
    fld_o.rd    = instr_i[4:0];
  end

  assign match_o = (instr_i[28:24] == FIXED_HI) && instr_i[21];
  assign undef_o = match_o &&
                   ((instr_i[23:22] != 2'b00) || (32'(instr_i[12:10]) > MAX_SHIFT));
endmodule

// File: rtl/addsub_ext_extend.sv
module addsub_ext_extend
  import addsub_ext_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic [XLEN-1:0] val_i,
  input  ext_size_e       size_i,
  input  logic            sign_i,
  input  logic [2:0]      shamt_i,
  output logic [XLEN-1:0] ext_o
);
  localparam int unsigned BW = 8;
  localparam int unsigned HW = 16;
  localparam int unsigned WW = 32;

  logic [XLEN-1:0] slice;

  always_comb begin
    unique case (size_i)
      SZ_BYTE: slice = {{(XLEN-BW){sign_i & val_i[BW-1]}}, val_i[BW-1:0]};
      SZ_HALF: slice = {{(XLEN-HW){sign_i & val_i[HW-1]}}, val_i[HW-1:0]};
      SZ_WORD: slice = {{(XLEN-WW){sign_i & val_i[WW-1]}}, val_i[WW-1:0]};
      default: slice = val_i;
    endcase
  end

  assign ext_o = slice << shamt_i;

  // R3: vacated low bits stay clear
  always_comb begin
    if (!$isunknown({shamt_i, ext_o}) && (32'(shamt_i) <= MAX_SHIFT))
      a_r3_low_clear: assert ((ext_o & ((XLEN'(1) << shamt_i) - XLEN'(1))) == '0);
  end
endmodule

// File: rtl/addsub_ext_adder.sv
module addsub_ext_adder #(
  parameter int unsigned XLEN = 64
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic            sub_i,
  input  logic            wide_i,
  output logic [XLEN-1:0] res_o,
  output logic [3:0]      nzcv_o
);
  localparam int unsigned HLEN = XLEN / 2;

  logic [XLEN-1:0] b_eff;
  logic [XLEN:0]   sum_w;
  logic [HLEN:0]   sum_n;
  logic            a_msb, b_msb, r_msb, cout;

  assign b_eff = sub_i ? ~b_i : b_i;
  assign sum_w = {1'b0, a_i} + {1'b0, b_eff} + (XLEN+1)'(sub_i);
  assign sum_n = {1'b0, a_i[HLEN-1:0]} + {1'b0, b_eff[HLEN-1:0]} + (HLEN+1)'(sub_i);

  always_comb begin
    if (wide_i) begin
      res_o = sum_w[XLEN-1:0];
      cout  = sum_w[XLEN];
      a_msb = a_i[XLEN-1];
      b_msb = b_eff[XLEN-1];
    end else begin
      res_o = {{(XLEN-HLEN){1'b0}}, sum_n[HLEN-1:0]};
      cout  = sum_n[HLEN];
      a_msb = a_i[HLEN-1];
      b_msb = b_eff[HLEN-1];
    end
    r_msb  = wide_i ? res_o[XLEN-1] : res_o[HLEN-1];
    nzcv_o = {r_msb, (res_o == '0), cout, (a_msb == b_msb) && (r_msb != a_msb)};
  end
endmodule

// File: rtl/addsub_ext_exec.sv
module addsub_ext_exec
  import addsub_ext_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic [INSN_W-1:0]   instr_i,
  output logic [RIDX_W-1:0]   rn_idx_o,
  output logic [RIDX_W-1:0]   rm_idx_o,
  input  logic [XLEN-1:0]     rn_data_i,
  input  logic [XLEN-1:0]     rm_data_i,
  input  logic [XLEN-1:0]     sp_data_i,
  output logic                valid_o,
  output logic                nomatch_o,
  output logic                undef_o,
  output logic                gpr_we_o,
  output logic [RIDX_W-1:0]   gpr_waddr_o,
  output logic                sp_we_o,
  output logic                flags_we_o,
  output logic [XLEN-1:0]     wdata_o,
  output logic [3:0]          nzcv_o
);
  localparam logic [RIDX_W-1:0] REG31 = '1;

  insn_fields_t    fld;
  logic            match, undef;
  logic [XLEN-1:0] op1, op2_src, op2, res;
  logic [3:0]      nzcv;
  logic            exec_ok;

  addsub_ext_decode u_dec (
    .instr_i (instr_i),
    .fld_o   (fld),
    .match_o (match),
    .undef_o (undef)
  );

  assign rn_idx_o = fld.rn;
  assign rm_idx_o = fld.rm;

  // index 31: stack pointer on the first source, zero on the second
  assign op1     = (fld.rn == REG31) ? sp_data_i : rn_data_i;
  assign op2_src = (fld.rm == REG31) ? '0 : rm_data_i;

  addsub_ext_extend #(.XLEN(XLEN)) u_ext (
    .val_i   (op2_src),
    .size_i  (fld.size),
    .sign_i  (fld.sign),
    .shamt_i (fld.shamt),
    .ext_o   (op2)
  );

  addsub_ext_adder #(.XLEN(XLEN)) u_add (
    .a_i    (op1),
    .b_i    (op2),
    .sub_i  (fld.sub),
    .wide_i (fld.wide),
    .res_o  (res),
    .nzcv_o (nzcv)
  );

  assign exec_ok = valid_i && match && !undef;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o     <= 1'b0;
      nomatch_o   <= 1'b0;
      undef_o     <= 1'b0;
      gpr_we_o    <= 1'b0;
      gpr_waddr_o <= '0;
      sp_we_o     <= 1'b0;
      flags_we_o  <= 1'b0;
      wdata_o     <= '0;
      nzcv_o      <= '0;
    end else begin
      valid_o    <= valid_i;
      nomatch_o  <= valid_i && !match;
      undef_o    <= valid_i && undef;
      gpr_we_o   <= exec_ok && (fld.rd != REG31);
      sp_we_o    <= exec_ok && (fld.rd == REG31) && !fld.setf;
      flags_we_o <= exec_ok && fld.setf;
      if (valid_i) begin
        gpr_waddr_o <= fld.rd;
        wdata_o     <= res;
        nzcv_o      <= nzcv;
      end
    end
  end

  a_r5_nomatch_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nomatch_o |-> !(gpr_we_o || sp_we_o || flags_we_o || undef_o));
  a_r3_undef_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    undef_o |-> !(gpr_we_o || sp_we_o || flags_we_o));
  a_r9_sp_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sp_we_o |-> !gpr_we_o && !flags_we_o);
  a_r9_gpr_not_31: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gpr_we_o |-> gpr_waddr_o != REG31);
  a_r11_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r11_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o && !gpr_we_o && !sp_we_o && !flags_we_o);
  a_r8_zero_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_we_o && nzcv_o[2]) |-> wdata_o == '0);
endmodule

// File: tb/test_addsub_ext_exec.sv
`timescale 1ns/1ps
module test_addsub_ext_exec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] instr = '0;
  logic [4:0]  rn_idx, rm_idx, gpr_waddr;
  logic [63:0] rn_data, rm_data, sp, wdata;
  logic        valid_o, nomatch, undef, gpr_we, sp_we, flags_we;
  logic [3:0]  nzcv;
  logic [63:0] gpr [32];

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  assign rn_data = gpr[rn_idx];
  assign rm_data = gpr[rm_idx];

  addsub_ext_exec i_addsub_ext_exec (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .instr_i(instr),
    .rn_idx_o(rn_idx), .rm_idx_o(rm_idx), .rn_data_i(rn_data),
    .rm_data_i(rm_data), .sp_data_i(sp), .valid_o(valid_o),
    .nomatch_o(nomatch), .undef_o(undef), .gpr_we_o(gpr_we),
    .gpr_waddr_o(gpr_waddr), .sp_we_o(sp_we), .flags_we_o(flags_we),
    .wdata_o(wdata), .nzcv_o(nzcv)
  );

  typedef struct packed {
    logic nm, ud, gw, sw, fw;
    logic [4:0] wa;
    logic [63:0] wd;
    logic [3:0] f;
  } exp_t;

  typedef struct packed {
    logic sf, op, s;
    logic [4:0] rm;
    logic [2:0] ext, sh;
    logic [4:0] rn, rd;
    logic [63:0] wd;
    logic [3:0] f;
    logic gw, sw, fw, ud;
  } vec_t;

  localparam vec_t TBL [10] = '{
    '{1'b1,1'b0,1'b0,5'd2, 3'b000,3'd0,5'd1, 5'd5, 64'h90,                  4'b0000,1'b1,1'b0,1'b0,1'b0}, // R2 uxt byte
    '{1'b1,1'b0,1'b1,5'd2, 3'b100,3'd0,5'd1, 5'd5, 64'hFFFF_FFFF_FFFF_FF90, 4'b1000,1'b1,1'b0,1'b1,1'b0}, // R2 R8 sxt byte
    '{1'b1,1'b1,1'b1,5'd1, 3'b011,3'd0,5'd1, 5'd6, 64'h0,                   4'b0110,1'b1,1'b0,1'b1,1'b0}, // R7 sub to zero
    '{1'b0,1'b0,1'b1,5'd3, 3'b010,3'd0,5'd3, 5'd9, 64'h0,                   4'b0111,1'b1,1'b0,1'b1,1'b0}, // R10 32-bit wrap
    '{1'b1,1'b0,1'b0,5'd1, 3'b000,3'd4,5'd31,5'd31,64'h1100,                4'b0000,1'b0,1'b1,1'b0,1'b0}, // R6 R9 R3 sp
    '{1'b1,1'b0,1'b0,5'd31,3'b111,3'd2,5'd1, 5'd7, 64'h10,                  4'b0000,1'b1,1'b0,1'b0,1'b0}, // R6 rm zero
    '{1'b1,1'b0,1'b1,5'd1, 3'b000,3'd0,5'd1, 5'd31,64'h20,                  4'b0000,1'b0,1'b0,1'b1,1'b0}, // R9 discard
    '{1'b1,1'b0,1'b0,5'd1, 3'b000,3'd5,5'd1, 5'd5, 64'h0,                   4'b0000,1'b0,1'b0,1'b0,1'b1}, // R3 shift 5
    '{1'b0,1'b1,1'b1,5'd4, 3'b101,3'd1,5'd1, 5'd10,64'h12,                  4'b0000,1'b1,1'b0,1'b1,1'b0}, // R7 R10 sxt half
    '{1'b0,1'b0,1'b0,5'd1, 3'b001,3'd0,5'd2, 5'd8, 64'h0000_0000_FFFF_FF90, 4'b0000,1'b1,1'b0,1'b0,1'b0}  // R10 zero-ext
  };

  function automatic logic [31:0] enc(logic sf, logic op, logic s, logic [4:0] rm,
                                      logic [2:0] ext, logic [2:0] sh, logic [4:0] rn, logic [4:0] rd);
    return {sf, op, s, 5'b01011, 2'b00, 1'b1, rm, ext, sh, rn, rd};
  endfunction

  function automatic exp_t ref_model(logic [31:0] w);
    exp_t e;
    int n;
    logic [63:0] mv, x, a, r, mask;
    logic [127:0] ua, ux, us;
    logic signed [127:0] sa, sx, sr, lim;
    e = '0;
    if (w[28:24] != 5'b01011 || !w[21]) begin e.nm = 1'b1; return e; end
    if (w[23:22] != 2'b00 || w[12:10] > 3'd4) begin e.ud = 1'b1; return e; end
    n  = w[31] ? 64 : 32;
    mask = w[31] ? '1 : 64'h0000_0000_FFFF_FFFF;
    mv = (w[20:16] == 5'd31) ? 64'd0 : gpr[w[20:16]];
    case (w[14:13])
      2'd0: x = w[15] ? {{56{mv[7]}},  mv[7:0]}  : {56'd0, mv[7:0]};
      2'd1: x = w[15] ? {{48{mv[15]}}, mv[15:0]} : {48'd0, mv[15:0]};
      2'd2: x = w[15] ? {{32{mv[31]}}, mv[31:0]} : {32'd0, mv[31:0]};
      default: x = mv;
    endcase
    x = (x << w[12:10]) & mask;
    a = ((w[9:5] == 5'd31) ? sp : gpr[w[9:5]]) & mask;
    ua = {64'd0, a};
    ux = {64'd0, x};
    if (n == 64) begin
      sa = $signed({{64{a[63]}}, a});
      sx = $signed({{64{x[63]}}, x});
    end else begin
      sa = $signed({{96{a[31]}}, a[31:0]});
      sx = $signed({{96{x[31]}}, x[31:0]});
    end
    if (w[30]) begin
      us = ua - ux;
      sr = sa - sx;
      e.f[1] = (ua >= ux);
    end else begin
      us = ua + ux;
      sr = sa + sx;
      e.f[1] = us[n];
    end
    r = us[63:0] & mask;
    lim = 128'sd1 <<< (n - 1);
    e.f[0] = (sr >= lim) || (sr < -lim);
    e.f[3] = r[n-1];
    e.f[2] = (r == 64'd0);
    e.wd = r;
    e.fw = w[29];
    e.wa = w[4:0];
    if (w[4:0] == 5'd31) e.sw = !w[29];
    else e.gw = 1'b1;
    return e;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic compare(string req, exp_t e);
    chk({req, " valid"}, 64'(valid_o), 64'd1);
    chk({req, " nomatch"}, 64'(nomatch), 64'(e.nm));
    chk({req, " undef"}, 64'(undef), 64'(e.ud));
    chk({req, " gpr_we"}, 64'(gpr_we), 64'(e.gw));
    chk({req, " sp_we"}, 64'(sp_we), 64'(e.sw));
    chk({req, " flags_we"}, 64'(flags_we), 64'(e.fw));
    if (e.gw) chk({req, " waddr"}, 64'(gpr_waddr), 64'(e.wa));
    if (e.gw || e.sw) chk({req, " wdata"}, wdata, e.wd);
    if (e.fw) chk({req, " nzcv"}, 64'(nzcv), 64'(e.f));
  endtask

  task automatic issue(logic [31:0] w);
    @(negedge clk);
    instr = w;
    valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    exp_t e;
    for (int i = 0; i < 32; i++) gpr[i] = 64'd0;
    gpr[1] = 64'h10;
    gpr[2] = 64'hFFFF_FFFF_FFFF_FF80;
    gpr[3] = 64'h0000_0000_8000_0000;
    gpr[4] = 64'h7FFF_FFFF_FFFF_FFFF;
    gpr[31] = 64'hDEAD_BEEF_0BAD_F00D;
    sp = 64'h1000;

    // R12: reset state
    repeat (3) @(negedge clk);
    chk("R12 reset enables", 64'({valid_o, nomatch, undef, gpr_we, sp_we, flags_we}), 64'd0);
    rst_n = 1'b1;

    // R1: read addresses follow the word
    @(negedge clk);
    instr = enc(1'b1, 1'b0, 1'b0, 5'd19, 3'b000, 3'd0, 5'd12, 5'd3);
    #1;
    chk("R1 rn_idx", 64'(rn_idx), 64'd12);
    chk("R1 rm_idx", 64'(rm_idx), 64'd19);

    for (int i = 0; i < 10; i++) begin
      vec_t v;
      v = TBL[i];
      issue(enc(v.sf, v.op, v.s, v.rm, v.ext, v.sh, v.rn, v.rd));
      e = '0;
      e.ud = v.ud; e.gw = v.gw; e.sw = v.sw; e.fw = v.fw;
      e.wa = v.rd; e.wd = v.wd; e.f = v.f;
      compare($sformatf("R2/R3/R6/R7/R8/R9/R10 vec%0d", i), e);
    end

    // R11: idle cycle after an accepted word
    @(negedge clk);
    chk("R11 idle valid", 64'(valid_o), 64'd0);
    chk("R11 idle enables", 64'({gpr_we, sp_we, flags_we}), 64'd0);

    // R5: broken fixed pattern
    issue(enc(1'b1, 1'b0, 1'b1, 5'd1, 3'b000, 3'd0, 5'd1, 5'd5) & ~32'h0020_0000);
    e = '0; e.nm = 1'b1;
    compare("R5 bit21 clear", e);
    issue((enc(1'b1, 1'b0, 1'b0, 5'd1, 3'b000, 3'd0, 5'd1, 5'd5) & ~32'h1F00_0000) | 32'h0A00_0000);
    compare("R5 bad high pattern", e);

    // R4: reserved field set
    issue(enc(1'b1, 1'b0, 1'b1, 5'd1, 3'b000, 3'd0, 5'd1, 5'd5) | 32'h0040_0000);
    e = '0; e.ud = 1'b1;
    compare("R4 reserved field", e);

    // random words against the reference model
    for (int k = 0; k < 600; k++) begin
      logic [31:0] w;
      for (int i = 0; i < 32; i++) gpr[i] = {$urandom, $urandom};
      sp = {$urandom, $urandom};
      w = $urandom;
      if (($urandom % 8) != 0) w = (w & ~32'h1F20_0000) | 32'h0B20_0000;
      if (($urandom % 4) != 0) w[23:22] = 2'b00;
      if (($urandom % 3) != 0) w[12:10] = 3'($urandom % 5);
      issue(w);
      compare("R2/R6/R7/R8/R9/R10 random", ref_model(w));
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule